// File: doc/BRIEF.md
# Counted-Frame Serial Command Port

This block is the serial control port of an eight-channel output driver. A host uses three pins to send it commands: an active-low frame select, a serial clock that idles high, and a data line. A fast system clock samples all three pins, resynchronises them and finds their edges. Data bits shift in on falling serial-clock edges, least significant bit first. When the frame select goes high again, the shifted word is committed to the command register, but only if the frame held exactly as many clocks as the command is wide.

Each command bit drives one output enable. Bits 0 to 3 drive the low-side channels 1 to 4 and bits 4 to 7 drive the high-side channels 1 to 4. A standby flag is raised whenever every enable is off. Per-channel short-circuit inputs, combined with a shared overtemperature input, force the matching enable off. This forced clear takes priority over a commit in the same cycle. The block also reports, for a separate status block, the number of clocks in the current frame, an under-count flag, an over-count flag, and a strobe with the bit index for each accepted data bit.

Top module: `serial_cmd_port`

## Requirements
- R1: After reset, `out_en` is 0, `standby` is 1, `frame_clks` is 0, and `under_cnt`, `over_cnt` and `bit_strobe` are 0.
- R2: A data bit shifts in only on a falling `sclk_pin` edge while `cs_n_pin` is low, and the first bit lands in bit 0. Serial-clock activity while `cs_n_pin` is high has no effect on `frame_clks`, `bit_strobe` or `out_en`.
- R3: On the rising edge of `cs_n_pin`, the shifted word is copied to `out_en` if the frame held exactly 8 falling clock edges. Bit i of `out_en` enables low-side channel i+1 for i=0..3 and high-side channel i-3 for i=4..7.
- R4: A frame with fewer than 8 clocks leaves `out_en` unchanged and sets `under_cnt` at the rising edge of `cs_n_pin`.
- R5: A frame with more than 8 clocks leaves `out_en` unchanged. `over_cnt` sets on the rising clock edge that follows the ninth falling edge. Data bits after the eighth do not shift.
- R6: `frame_clks` counts the falling clock edges in a frame and saturates at 15; it does not wrap.
- R7: `standby` is 1 exactly when `out_en` is all zero.
- R8: While `fault_short[i]` and `over_temp` are both 1, `out_en[i]` is forced to 0. This clear wins over a commit in the same cycle, and the bit stays off until a later valid frame sets it. A short without overtemperature, or overtemperature without a short, has no effect.
- R9: `bit_strobe` pulses once for each of the first 8 falling clock edges in a frame, and `bit_idx` carries 0 to 7 in order.
- R10: The falling edge of `cs_n_pin` clears `frame_clks`, `under_cnt` and `over_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n_pin | input | 1 | Frame select pin, active low |
| sclk_pin | input | 1 | Serial clock pin, idles high |
| sdi_pin | input | 1 | Serial data pin |
| fault_short | input | 8 | Per-channel short-circuit indication |
| over_temp | input | 1 | Shared overtemperature indication |
| out_en | output | 8 | Channel enables (command register) |
| standby | output | 1 | All channels off |
| frame_clks | output | 4 | Falling clock edges in the current or last frame, saturating |
| under_cnt | output | 1 | Last frame ended with fewer than 8 clocks |
| over_cnt | output | 1 | Current frame has seen more than 8 clocks |
| bit_strobe | output | 1 | One-cycle pulse per accepted data bit |
| bit_idx | output | 3 | Index of the bit just accepted |

## Verification
The assertions assume the three pins are quasi-static relative to the system clock. Each pin level must hold for at least two system cycles, and a serial-clock edge must not land in the same synchronised cycle as a frame-select edge. The stimulus meets this by changing pins only on the inactive system-clock edge, holding every serial-clock phase for several system cycles, and leaving settling gaps around every frame-select transition. Fault inputs are driven as static levels across whole frames, so their effect is judged after the pipeline has settled.

// File: rtl/scp_pkg.sv
package scp_pkg;
   // reset levels of the idle serial pins
   localparam logic CS_IDLE   = 1'b1;
   localparam logic SCLK_IDLE = 1'b1;
   localparam logic SDI_IDLE  = 1'b0;

   function automatic int unsigned sat_max(input int unsigned w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/scp_pin_sync.sv
module scp_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   initial begin
      assert_sync_depth_R2: assert (STAGES >= 2)
         else $error("pin synchroniser needs two or more stages");
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= RST_VAL;
      else        prev <= chain[STAGES-1];

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;
endmodule

// File: rtl/scp_frame_ctr.sv
module scp_frame_ctr #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4,
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             frame_end,
   input  logic             active,
   input  logic             clk_fall,
   input  logic             clk_rise,
   output logic [CNT_W-1:0] cnt,
   output logic             shift_en,
   output logic             exact,
   output logic             under,
   output logic             over,
   output logic             strobe,
   output logic [IDX_W-1:0] idx
);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(scp_pkg::sat_max(CNT_W));
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

   initial begin
      assert_cnt_room_R6: assert (scp_pkg::sat_max(CNT_W) > DATA_W)
         else $error("counter too narrow to see an over-long frame");
   end

   logic tick;
   assign tick     = active & clk_fall;
   assign shift_en = tick & (cnt < CNT_FULL);
   assign exact    = (cnt == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         under  <= 1'b0;
         over   <= 1'b0;
         strobe <= 1'b0;
         idx    <= '0;
      end else begin
         strobe <= shift_en;
         if (shift_en) idx <= cnt[IDX_W-1:0];
         if (frame_start) begin
            cnt   <= '0;
            under <= 1'b0;
            over  <= 1'b0;
         end else begin
            if (tick && cnt != CNT_MAX)             cnt   <= cnt + 1'b1;
            if (frame_end && cnt < CNT_FULL)        under <= 1'b1;
            if (active && clk_rise && cnt > CNT_FULL) over <= 1'b1;
         end
      end
   end

   assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !frame_start) |=> (cnt == CNT_MAX));
   assert_over_needs_nine_R5: assert property (@(posedge clk) disable iff (!rst_n)
      over |-> (cnt > CNT_FULL));
   assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cnt == '0 && !under && !over));
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [DATA_W-1:0] word
);
   generate
      if (DATA_W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)        word <= '0;
            else if (shift_en) word <= din;
      end else begin : g_wide
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)        word <= '0;
            else if (shift_en) word <= {din, word[DATA_W-1:1]};
      end
   endgenerate

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));
endmodule

// File: rtl/scp_cmd_reg.sv
module scp_cmd_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [DATA_W-1:0] new_cmd,
   input  logic [DATA_W-1:0] kill,
   output logic [DATA_W-1:0] cmd
);
   logic [DATA_W-1:0] cmd_nxt;

   always_comb begin
      cmd_nxt = commit ? new_cmd : cmd;
      cmd_nxt = cmd_nxt & ~kill;   // protection clear outranks a commit
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cmd <= '0;
      else        cmd <= cmd_nxt;

   assert_kill_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|kill) |=> ((cmd & $past(kill)) == '0));
   assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && kill == '0) |=> $stable(cmd));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_pin,
   input  logic              sclk_pin,
   input  logic              sdi_pin,
   input  logic [DATA_W-1:0] fault_short,
   input  logic              over_temp,
   output logic [DATA_W-1:0] out_en,
   output logic              standby,
   output logic [CNT_W-1:0]  frame_clks,
   output logic              under_cnt,
   output logic              over_cnt,
   output logic              bit_strobe,
   output logic [IDX_W-1:0]  bit_idx
);
   logic cs_lvl, cs_rise, cs_fall;
   logic ck_lvl, ck_rise, ck_fall;
   logic di_lvl, di_rise, di_fall;
   logic shift_en, exact, commit;
   logic [DATA_W-1:0] word, kill;

   scp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(scp_pkg::CS_IDLE)) u_cs (
      .clk(clk), .rst_n(rst_n), .pin(cs_n_pin),
      .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));
   scp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(scp_pkg::SCLK_IDLE)) u_ck (
      .clk(clk), .rst_n(rst_n), .pin(sclk_pin),
      .level(ck_lvl), .rise(ck_rise), .fall(ck_fall));
   scp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(scp_pkg::SDI_IDLE)) u_di (
      .clk(clk), .rst_n(rst_n), .pin(sdi_pin),
      .level(di_lvl), .rise(di_rise), .fall(di_fall));

   scp_frame_ctr #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .frame_start(cs_fall), .frame_end(cs_rise), .active(~cs_lvl),
      .clk_fall(ck_fall), .clk_rise(ck_rise),
      .cnt(frame_clks), .shift_en(shift_en), .exact(exact),
      .under(under_cnt), .over(over_cnt),
      .strobe(bit_strobe), .idx(bit_idx));

   scp_shifter #(.DATA_W(DATA_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(di_lvl), .word(word));

   assign commit = cs_rise & exact;
   assign kill   = fault_short & {DATA_W{over_temp}};

   scp_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .commit(commit), .new_cmd(word),
      .kill(kill), .cmd(out_en));

   assign standby = ~|out_en;

   logic unused_edges;
   assign unused_edges = di_rise ^ di_fall ^ ck_lvl;

   assert_strobe_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> (frame_clks == CNT_W'(bit_idx) + 1'b1));
   assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lvl && $past(cs_lvl)) |-> !bit_strobe);
   assert_commit_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && frame_clks != CNT_W'(DATA_W) && kill == '0) |=> $stable(out_en));
endmodule

// File: tb/serial_cmd_port_tb.sv
module serial_cmd_port_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n_pin = 1'b1, sclk_pin = 1'b1, sdi_pin = 1'b0;
   logic [7:0] fault_short = '0;
   logic       over_temp = 1'b0;
   logic [7:0] out_en;
   logic       standby, under_cnt, over_cnt, bit_strobe;
   logic [3:0] frame_clks;
   logic [2:0] bit_idx;

   serial_cmd_port u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
      .sdi_pin(sdi_pin), .fault_short(fault_short), .over_temp(over_temp),
      .out_en(out_en), .standby(standby), .frame_clks(frame_clks),
      .under_cnt(under_cnt), .over_cnt(over_cnt),
      .bit_strobe(bit_strobe), .bit_idx(bit_idx));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic [7:0] en;
      logic       under;
      logic       over;
      logic [3:0] cnt;
      int         strobes;
      string      tag;
   } exp_t;

   exp_t q[$];
   event frame_done;
   int   compared = 0, mismatched = 0;
   int   strobe_seen = 0, idx_bad = 0;
   logic [7:0] model_cmd = '0;
   bit   finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // strobe monitor (R9): order of indices within a frame
   always @(negedge clk)
      if (bit_strobe) begin
         if (int'(bit_idx) != strobe_seen) idx_bad++;
         strobe_seen++;
      end

   // scoreboard monitor
   initial begin
      exp_t e;
      forever begin
         @(frame_done);
         e = q.pop_front();
         chk(out_en == e.en,      {e.tag, " R3 out_en"},  out_en, e.en);
         chk(standby == (e.en == 0), "R7 standby", standby, (e.en == 0));
         chk(under_cnt == e.under, {e.tag, " R4 under"}, under_cnt, e.under);
         chk(over_cnt == e.over,   {e.tag, " R5 over"},  over_cnt, e.over);
         chk(frame_clks == e.cnt,  {e.tag, " R6 count"}, frame_clks, e.cnt);
         chk(strobe_seen == e.strobes && idx_bad == 0, {e.tag, " R9 strobes"},
             strobe_seen, e.strobes);
      end
   end

   task automatic send_frame(input int n, input logic [7:0] d, input string tag);
      exp_t e;
      logic [7:0] kill;
      cs_n_pin = 1'b0;
      cyc(6);
      chk(frame_clks == 0 && !under_cnt && !over_cnt, "R10 frame start clear",
          {frame_clks, under_cnt, over_cnt}, 0);
      strobe_seen = 0;
      idx_bad = 0;
      for (int i = 0; i < n; i++) begin
         sdi_pin  = (i < 8) ? d[i] : ~d[i % 8];
         cyc(1);
         sclk_pin = 1'b0;
         cyc(HALF);
         sclk_pin = 1'b1;
         cyc(HALF);
      end
      cs_n_pin = 1'b1;
      cyc(6);
      kill = fault_short & {8{over_temp}};
      if (n == 8) model_cmd = d;
      model_cmd = model_cmd & ~kill;
      e.en = model_cmd;
      e.under = (n < 8);
      e.over = (n > 8);
      e.cnt = (n > 15) ? 4'd15 : 4'(n);
      e.strobes = (n > 8) ? 8 : n;
      e.tag = tag;
      q.push_back(e);
      ->frame_done;
      cyc(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R1 reset state
      chk(out_en == 0 && standby, "R1 reset enables", out_en, 0);
      chk(frame_clks == 0 && !under_cnt && !over_cnt && !bit_strobe,
          "R1 reset flags", {frame_clks, under_cnt, over_cnt, bit_strobe}, 0);
      rst_n = 1'b1;
      cyc(3);

      send_frame(8, 8'hA5, "lsb-first");           // R2 R3
      send_frame(8, 8'h0F, "low-side");            // R3 channel map
      send_frame(8, 8'hF0, "high-side");
      send_frame(5, 8'h33, "short frame");         // R4
      send_frame(9, 8'h11, "nine clocks");         // R5
      send_frame(20, 8'h22, "long frame");         // R6
      send_frame(8, 8'h00, "all off");             // R7
      send_frame(8, 8'hFF, "all on");

      // R2: clock toggling with select high is ignored
      for (int i = 0; i < 5; i++) begin
         sclk_pin = 1'b0; cyc(HALF); sclk_pin = 1'b1; cyc(HALF);
      end
      chk(frame_clks == 8 && out_en == 8'hFF, "R2 idle clocks ignored",
          {frame_clks, out_en}, {4'd8, 8'hFF});

      // R8: short alone, temp alone
      fault_short = 8'h04; cyc(4);
      chk(out_en == 8'hFF, "R8 short alone", out_en, 8'hFF);
      fault_short = 8'h00; over_temp = 1'b1; cyc(4);
      chk(out_en == 8'hFF, "R8 temp alone", out_en, 8'hFF);
      // both: clear channel 2 (low-side 3)
      fault_short = 8'h04; cyc(4);
      chk(out_en == 8'hFB, "R8 kill", out_en, 8'hFB);
      model_cmd = 8'hFB;
      // priority over commit while fault held
      send_frame(8, 8'hFF, "kill over commit");
      fault_short = 8'h00; over_temp = 1'b0; cyc(4);
      chk(out_en == 8'hFB, "R8 stays off after fault", out_en, 8'hFB);
      send_frame(8, 8'hFF, "re-enable");

      cyc(4);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule